// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Debug-Mode Select

This block is a test access port driven by a serial test clock. It carries a boundary register over a small, parameterised set of pins. A mode strap is sampled while the chip is held in reset.

When the sampled strap is high, the port runs in boundary-scan mode. Three instructions are recognised: SAMPLE, EXTEST and BYPASS. SAMPLE captures pin and core values without disturbing the pads. EXTEST hands control of the output pads to the update latches.

When the sampled strap is low, the port runs in debug mode. Every data-register scan then returns a fixed 32-bit identification word, and that word does not follow the standard identification-code layout. A mode change is only accepted across a full reset, so the port never switches personality in the middle of a session.

Top module: `bscanTap`

## Requirements
- R1: The controller follows the standard 16-state test-port state graph on the rising edge of `tck`. It returns to Test-Logic-Reset after five consecutive rising edges with `tms` high, and at once when `trstN` is low. Reaching Test-Logic-Reset sets the instruction to BYPASS.
- R2: The instruction register is 4 bits wide and shifts least significant bit first from `tdi` toward `tdo`. Capture-IR loads the pattern 0001, so the first bit shifted out is 1 and the next three are 0.
- R3: Opcode 0000 is EXTEST, 0001 is SAMPLE and 1111 is BYPASS. Every other opcode behaves as BYPASS. BYPASS selects a 1-bit register that captures 0 and delays `tdi` by one shift.
- R4: The boundary register is NUM_IN + 2*NUM_OUT bits long. Bits 0..NUM_IN-1 observe `pinIn`, the next NUM_OUT bits are the pad data cells and the top NUM_OUT bits are the pad enable cells. Bit 0 is the first bit shifted out, and `tdi` enters at the top bit.
- R5: Under SAMPLE, Capture-DR loads `pinIn`, `coreOut` and `coreOe` into their cells, and the pads keep following `coreOut` and `coreOe`.
- R6: Under EXTEST in boundary-scan mode, `padOut` and `padOe` come from the update latches. An enable value of 1 drives the pad and 0 places it in high impedance.
- R7: The update latches load from the boundary register on the falling edge of `tck` in Update-DR, and only while SAMPLE or EXTEST is selected. Scans through any other register leave them unchanged.
- R8: `tdo` and `tdoEn` change on the falling edge of `tck`. `tdoEn` is high only while the controller is in Shift-IR or Shift-DR.
- R9: The mode strap `modeSel` is captured only while `trstN` and `chipRstN` are both low. A change made at any other time, including while only `trstN` is low, has no effect.
- R10: In debug mode every data-register scan captures and shifts out the 32-bit DEBUG_ID word least significant bit first, whatever the instruction. The pads always follow the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| chipRstN | input | 1 | Chip reset, active low, used only to qualify mode capture |
| modeSel | input | 1 | Mode strap: 1 selects boundary scan, 0 selects debug |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdoEn | output | 1 | High while `tdo` carries shift data |
| pinIn | input | NUM_IN | Input pad values |
| coreOut | input | NUM_OUT | Functional output data from the core |
| coreOe | input | NUM_OUT | Functional output enables from the core |
| padOut | output | NUM_OUT | Data driven toward the output pads |
| padOe | output | NUM_OUT | Output pad enables (1 drives, 0 high impedance) |

## Verification
Several properties are checked on every clock edge. Five rising edges with `tms` high always land in Test-Logic-Reset. Capture-IR always yields 0001. The bypass bit echoes the previous `tdi`. A debug capture loads the identification word. The update latches never move outside Update-DR. The mode strap stays fixed while the test reset is high. `tdoEn` tracks the shift states.

Other behaviour appears only in the bench's scenarios, where a behavioural reference model is compared on every clock. That covers bit ordering across the boundary register and the falling-edge timing of `tdo`. It also covers the difference between SAMPLE and EXTEST at the pads, the decode of unused opcodes, and the rule that a test reset alone does not change the mode.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic selBsr;
    logic selId;
    logic selBypass;
    logic extest;
    logic irLsb;
  } strobe_t;

endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import bscan_pkg::*;
(
  input  logic    tck,
  input  logic    trstN,
  input  logic    chipRstN,
  input  logic    modeSel,
  input  logic    tms,
  input  logic    tdi,
  output strobe_t stb
);

  tapState_e state, stateNext;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  logic modeLatched;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:  stateNext = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   stateNext = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: stateNext = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateNext = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateNext = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateNext = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateNext = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: stateNext = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateNext = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateNext = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateNext = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateNext = tms ? ST_SEL_DR : ST_IDLE;
      default:   stateNext = ST_RESET;
    endcase
  end

  // instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
    end else if (state == ST_CAP_IR) begin
      irShift <= IR_CAPTURE_PAT;
    end else if (state == ST_SH_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  // instruction hold stage, loads on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                  irReg <= OP_BYPASS;
    else if (state == ST_RESET)  irReg <= OP_BYPASS;
    else if (state == ST_UPD_IR) irReg <= irShift;
  end

  // mode strap: transparent only while both resets are held
  always_latch begin
    if (!trstN && !chipRstN) modeLatched = modeSel;
  end

  logic isExtest, isSample;
  assign isExtest = (irReg == OP_EXTEST);
  assign isSample = (irReg == OP_SAMPLE);

  always_comb begin
    stb.captureDr = (state == ST_CAP_DR);
    stb.shiftDr   = (state == ST_SH_DR);
    stb.updateDr  = (state == ST_UPD_DR);
    stb.shiftIr   = (state == ST_SH_IR);
    stb.selId     = !modeLatched;
    stb.selBsr    = modeLatched && (isExtest || isSample);
    stb.selBypass = modeLatched && !(isExtest || isSample);
    stb.extest    = modeLatched && isExtest;
    stb.irLsb     = irShift[0];
  end

  // ---------------- assertions ----------------
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               tmsRun <= '0;
    else if (!tms)            tmsRun <= '0;
    else if (tmsRun != 3'd7)  tmsRun <= tmsRun + 3'd1;
  end

  assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun >= 3'd5) |-> (state == ST_RESET));

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_CAP_IR) |=> (irShift == 4'b0001));

  assert_mode_held_R9: assert property (@(posedge tck) disable iff (!trstN)
    trstN |=> $stable(modeLatched));

endmodule

// File: rtl/bscanPath.sv
module bscanPath
  import bscan_pkg::*;
#(
  parameter int          NUM_IN   = 4,
  parameter int          NUM_OUT  = 3,
  parameter logic [31:0] DEBUG_ID = 32'hC3A5_6E18
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  strobe_t            stb,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe,
  output logic               tdo,
  output logic               tdoEn
);

  localparam int BSR_W   = NUM_IN + 2 * NUM_OUT;
  localparam int DATA_LO = NUM_IN;
  localparam int EN_LO   = NUM_IN + NUM_OUT;
  localparam int ID_W    = 32;

  logic [BSR_W-1:0]   bsr;
  logic [ID_W-1:0]    idShift;
  logic               bypassBit;
  logic [NUM_OUT-1:0] updData;
  logic [NUM_OUT-1:0] updEn;
  logic               drLsb;

  // boundary register: capture / shift
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsr <= '0;
    end else if (stb.selBsr) begin
      if (stb.captureDr)    bsr <= {coreOe, coreOut, pinIn};
      else if (stb.shiftDr) bsr <= {tdi, bsr[BSR_W-1:1]};
    end
  end

  // bypass bit
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
    end else if (stb.selBypass) begin
      if (stb.captureDr)    bypassBit <= 1'b0;
      else if (stb.shiftDr) bypassBit <= tdi;
    end
  end

  // debug identification word
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= '0;
    end else if (stb.selId) begin
      if (stb.captureDr)    idShift <= DEBUG_ID;
      else if (stb.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // update latches, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      updData <= '0;
      updEn   <= '0;
    end else if (stb.updateDr && stb.selBsr) begin
      updData <= bsr[DATA_LO +: NUM_OUT];
      updEn   <= bsr[EN_LO +: NUM_OUT];
    end
  end

  always_comb begin
    if (stb.selBsr)     drLsb = bsr[0];
    else if (stb.selId) drLsb = idShift[0];
    else                drLsb = bypassBit;
  end

  // serial output stage, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= stb.shiftIr ? stb.irLsb : drLsb;
      tdoEn <= stb.shiftIr || stb.shiftDr;
    end
  end

  // pad multiplexers, one per output pin
  for (genvar g = 0; g < NUM_OUT; g++) begin : gPad
    assign padOut[g] = stb.extest ? updData[g] : coreOut[g];
    assign padOe[g]  = stb.extest ? updEn[g]   : coreOe[g];
  end

  // ---------------- assertions ----------------
  assert_bypass_delay_R3: assert property (@(posedge tck) disable iff (!trstN)
    (stb.selBypass && stb.shiftDr) |=> (bypassBit == $past(tdi)));

  assert_upd_hold_R7: assert property (@(posedge tck) disable iff (!trstN)
    !stb.updateDr |-> ($stable(updData) && $stable(updEn)));

  assert_tdoen_window_R8: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (stb.shiftDr || stb.shiftIr));

  assert_id_capture_R10: assert property (@(posedge tck) disable iff (!trstN)
    (stb.selId && stb.captureDr) |=> (idShift == DEBUG_ID));

endmodule

// File: rtl/bscanTap.sv
module bscanTap
  import bscan_pkg::*;
#(
  parameter int          NUM_IN   = 4,
  parameter int          NUM_OUT  = 3,
  parameter logic [31:0] DEBUG_ID = 32'hC3A5_6E18
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               chipRstN,
  input  logic               modeSel,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoEn,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe
);

  strobe_t stb;

  tapCtrl ctrl_i (
    .tck      (tck),
    .trstN    (trstN),
    .chipRstN (chipRstN),
    .modeSel  (modeSel),
    .tms      (tms),
    .tdi      (tdi),
    .stb      (stb)
  );

  bscanPath #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .DEBUG_ID (DEBUG_ID)
  ) path_i (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .stb     (stb),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .padOut  (padOut),
    .padOe   (padOe),
    .tdo     (tdo),
    .tdoEn   (tdoEn)
  );

endmodule

// File: tb/bscanTap_tb.sv
module bscanTap_tb_top;

  localparam int NI = 4;
  localparam int NO = 3;
  localparam int BW = NI + 2 * NO;
  localparam logic [31:0] DBG_ID = 32'hC3A5_6E18;

  // bench-side state numbering
  localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3,  S_SHD = 4;
  localparam int S_E1D = 5,  S_PD  = 6,  S_E2D = 7,  S_UDR = 8,  S_SIR = 9;
  localparam int S_CIR = 10, S_SHI = 11, S_E1I = 12, S_PI  = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic trstN = 1'b0, chipRstN = 1'b0, modeSel = 1'b1;
  logic tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] coreOut = '0, coreOe = '0;
  logic [NO-1:0] padOut, padOe;

  always #2 tck = ~tck;

  bscanTap #(.NUM_IN(NI), .NUM_OUT(NO), .DEBUG_ID(DBG_ID)) dut_i (
    .tck(tck), .trstN(trstN), .chipRstN(chipRstN), .modeSel(modeSel),
    .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .pinIn(pinIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe));

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // reference model state
  int st = S_TLR;
  logic [3:0] mIrSh = '0, mIr = 4'hF;
  logic [BW-1:0] mBsr = '0;
  logic mByp = 1'b0, mMode = 1'b1;
  logic [31:0] mId = '0;
  logic [NO-1:0] mUd = '0, mUe = '0;
  logic mTdo = 1'b0, mTdoEn = 1'b0;

  function automatic int nextSt(int s, logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;
      S_CDR: return t ? S_E1D : S_SHD;
      S_SHD: return t ? S_E1D : S_SHD;
      S_E1D: return t ? S_UDR : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UDR : S_SHD;
      S_UDR: return t ? S_SDR : S_RTI;
      S_SIR: return t ? S_TLR : S_CIR;
      S_CIR: return t ? S_E1I : S_SHI;
      S_SHI: return t ? S_E1I : S_SHI;
      S_E1I: return t ? S_UIR : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UIR : S_SHI;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic bit usesBsr();
    return mMode && (mIr == 4'b0000 || mIr == 4'b0001);
  endfunction

  task automatic modelReset();
    st = S_TLR; mIrSh = '0; mIr = 4'hF; mBsr = '0; mByp = 1'b0;
    mId = '0; mUd = '0; mUe = '0; mTdo = 1'b0; mTdoEn = 1'b0;
  endtask

  task automatic modelRise(input logic t, input logic d);
    if (st == S_CIR) mIrSh = 4'b0001;
    if (st == S_SHI) mIrSh = {d, mIrSh[3:1]};
    if (st == S_CDR) begin
      if (!mMode)        mId = DBG_ID;
      else if (usesBsr()) mBsr = {coreOe, coreOut, pinIn};
      else               mByp = 1'b0;
    end
    if (st == S_SHD) begin
      if (!mMode)        mId = {d, mId[31:1]};
      else if (usesBsr()) mBsr = {d, mBsr[BW-1:1]};
      else               mByp = d;
    end
    st = nextSt(st, t);
  endtask

  task automatic modelFall();
    logic lsb;
    lsb = !mMode ? mId[0] : (usesBsr() ? mBsr[0] : mByp);
    mTdo = (st == S_SHI) ? mIrSh[0] : lsb;
    mTdoEn = (st == S_SHI) || (st == S_SHD);
    if (st == S_UDR && usesBsr()) begin
      mUd = mBsr[NI +: NO];
      mUe = mBsr[NI + NO +: NO];
    end
    if (st == S_TLR) mIr = 4'hF;
    if (st == S_UIR) mIr = mIrSh;
  endtask

  task automatic compare();
    logic ext;
    logic [NO-1:0] eOut, eOe;
    ext = mMode && (mIr == 4'b0000);
    eOut = ext ? mUd : coreOut;
    eOe  = ext ? mUe : coreOe;
    nChecks++;
    if (tdoEn !== mTdoEn || (mTdoEn && tdo !== mTdo) || padOut !== eOut || padOe !== eOe) begin
      nFails++;
      $display("FAIL %s t=%0t: tdoEn=%b tdo=%b padOut=%b padOe=%b / expected tdoEn=%b tdo=%b padOut=%b padOe=%b",
               curReq, $time, tdoEn, tdo, padOut, padOe, mTdoEn, mTdo, eOut, eOe);
    end
  endtask

  // one full test clock; inputs change in the low phase only
  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    if (!trstN && !chipRstN) mMode = modeSel;
    @(posedge tck);
    if (trstN) modelRise(t, d); else modelReset();
    @(negedge tck);
    if (trstN) modelFall(); else modelReset();
    #1 compare();
  endtask

  task automatic holdReset(input logic both, input logic m, input int n);
    modeSel = m; chipRstN = !both; trstN = 1'b0;
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    trstN = 1'b1; chipRstN = 1'b1;
    step(1'b0, 1'b0);
  endtask

  task automatic irScan(input logic [3:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic drScan(input logic [63:0] d, input int n);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 / R9: power-up reset with strap high
    curReq = "R1";
    holdReset(1'b1, 1'b1, 3);
    pinIn = 4'b1010; coreOut = 3'b011; coreOe = 3'b101;
    step(0, 0);

    // R1: wander through the pause states, then five ones
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0);
    step(1, 0); step(0, 1); step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);

    // R2: instruction capture pattern appears on tdo
    curReq = "R2";
    irScan(4'b0001);

    // R5 / R4: SAMPLE capture of pins and core, shift a new pattern
    curReq = "R5";
    drScan(64'h2B5, BW);
    curReq = "R4";
    pinIn = 4'b0110; coreOut = 3'b100; coreOe = 3'b011;
    drScan(64'h3C9, BW);

    // R6: EXTEST exposes the latched pattern
    curReq = "R6";
    irScan(4'b0000);
    coreOut = 3'b111; coreOe = 3'b000;
    drScan(64'h1A7, BW);
    drScan(64'h258, BW);

    // R3 / R7: bypass opcodes, update latches must hold
    curReq = "R3";
    irScan(4'b1111);
    drScan(64'h96, 8);
    irScan(4'b0110);
    drScan(64'h5B, 8);
    curReq = "R7";
    irScan(4'b0000);
    step(0, 0);

    // R8: test reset in the middle of a shift drops the output enable
    curReq = "R8";
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    trstN = 1'b0; step(0, 0); step(0, 0);
    trstN = 1'b1; step(0, 0);

    // R9: strap changes without a full reset are ignored
    curReq = "R9";
    modeSel = 1'b0;
    irScan(4'b0000);
    drScan(64'h0F3, BW);
    holdReset(1'b0, 1'b0, 3);
    irScan(4'b0000);
    drScan(64'h10C, BW);

    // R10: full reset with strap low enters debug mode
    curReq = "R10";
    holdReset(1'b1, 1'b0, 3);
    modeSel = 1'b1;
    drScan(64'h0, 32);
    irScan(4'b0000);
    coreOut = 3'b010; coreOe = 3'b110;
    drScan(64'hFFFF_0000_1234_5678, 40);
    irScan(4'b0001);
    drScan(64'hA5A5_A5A5, 32);

    // R9: return to scan mode only through a full reset
    curReq = "R9";
    holdReset(1'b1, 1'b1, 2);
    irScan(4'b0000);
    drScan(64'h155, BW);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule